// File: doc/BRIEF.md
# Frame-Decimating Video Input Buffer

This block sits between a video decoder that produces one pixel per clock at a steady rate and a consumer that accepts pixels far more slowly, through a valid/ready handshake. It lowers the data rate by whole frames. A frame is kept only if a frame buffer is free at the moment the frame starts. A kept frame is written in full and later passed on unchanged. A frame that arrives while every buffer is in use is discarded as a unit. The consumer therefore only ever sees complete, consecutive-in-time frames, and motion appears faster than real time.

The frame buffers live in external memory made of two single-port banks. Pixel p of a frame is stored in bank p[0]. A frame being written thus never touches the same bank on two back-to-back pixels. The reader takes its slot on the idle bank whenever the writer is busy on the other one. The buffers are used in a ring. Write and read positions come from separate counters, and the output carries a start-of-frame bit on the first pixel of each delivered frame. Input and consumer share one clock; pacing comes only from the handshake. FRAME_PIX and OQ_DEPTH are powers of two, with FRAME_PIX at least 4 and NBUF at least 2.

Top module: `frame_decim_buf`

## Requirements
- R1: A frame begins only on a cycle with in_valid=1 and in_sof=1; that pixel is pixel 0. Valid pixels with in_sof=0 that arrive while no frame is being stored are ignored and never reach the output.
- R2: At a frame start the frame is stored if the next buffer in ring order is not holding an undelivered frame; otherwise every pixel of that frame is discarded.
- R3: Buffers are filled and drained in the same ring order, so delivered frames appear in the order they arrived, each delivered at most once.
- R4: Pixel p of a frame stored in buffer b is written to bank p[0] at bank address {b, p>>1} (buffer index in the upper bits), with mem_we bit 0 or 1 selecting the bank.
- R5: No bank is written and read in the same cycle, and at most one bank is written per cycle.
- R6: A buffer becomes readable only after all FRAME_PIX pixels of its frame are written. A frame cut short by a new in_sof is discarded and its buffer is reused for the new frame. Pixels beyond FRAME_PIX before the next in_sof are ignored.
- R7: A buffer is released for reuse only after the read of its last pixel has been issued; until then, frames that would need it are discarded.
- R8: While out_valid=1 and out_ready=0, out_valid, out_data and out_sof hold steady. out_sof=1 marks pixel 0 of each delivered frame and no other pixel.
- R9: After reset, out_valid, mem_we and mem_re are 0 and all buffers are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by input, memory and consumer |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel present |
| in_sof | input | 1 | Input pixel is the first of a frame |
| in_data | input | DATA_W | Input pixel value |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer accepts the output pixel |
| out_sof | output | 1 | Output pixel is the first of a frame |
| out_data | output | DATA_W | Output pixel value |
| mem_we | output | 2 | Per-bank write strobe (bit = bank) |
| mem_re | output | 2 | Per-bank read strobe (bit = bank) |
| mem_addr0 | output | AW | Bank 0 address |
| mem_addr1 | output | AW | Bank 1 address |
| mem_wdata | output | DATA_W | Write data to both banks |
| mem_rdata0 | input | DATA_W | Bank 0 read data, one cycle after its read strobe |
| mem_rdata1 | input | DATA_W | Bank 1 read data, one cycle after its read strobe |

## Verification
The assertions watch on every cycle that no bank is written and read together and that writes go to at most one bank. They also check that a buffer is released only while it holds a finished frame, and that a buffer becomes readable only from the filling state. The output must hold still under back-pressure, and it must be idle after reset. Which frames survive, and whether each delivered frame is a whole, unaltered input frame in arrival order, can only be shown by the bench's scenarios. These cover a stalled consumer, truncated and overlong frames, stray pixels and a sweep of consumer ready rates. The bank and address layout is confirmed by reading the modelled memories.

// File: rtl/fdb_pkg.sv
package fdb_pkg;
  typedef enum logic [1:0] {
    BUF_FREE = 2'd0,
    BUF_FILL = 2'd1,
    BUF_FULL = 2'd2
  } buf_state_t;
endpackage

// File: rtl/fdb_sof_det.sv
// Input register stage: captures the pixel stream and flags frame starts.
module fdb_sof_det #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [DATA_W-1:0] in_data,
  output logic              s1_valid,
  output logic              s1_start,
  output logic [DATA_W-1:0] s1_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_start <= 1'b0;
      s1_data  <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_start <= in_valid & in_sof;
      s1_data  <= in_data;
    end
  end
endmodule

// File: rtl/fdb_buf_mgr.sv
// Buffer ownership and write side: allocation at frame start, write counter,
// bank steering and registered write strobes.
module fdb_buf_mgr
  import fdb_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int FRAME_PIX = 64,
  parameter int NBUF      = 2,
  localparam int PW = $clog2(FRAME_PIX),
  localparam int BW = $clog2(NBUF),
  localparam int AW = BW + PW - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_valid,
  input  logic              s1_start,
  input  logic [DATA_W-1:0] s1_data,
  input  logic              done,
  input  logic [BW-1:0]     done_buf,
  output logic [NBUF-1:0]   buf_full,
  output logic              wr_go_nxt,
  output logic              wr_bank_nxt,
  output logic [1:0]        wr_we,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  buf_state_t       st [NBUF];
  logic [BW-1:0]    wr_ptr;
  logic [PW-1:0]    pix;
  logic             filling;
  logic             start_ok, cont, last;
  logic [PW-1:0]    wr_pix;

  always_comb begin
    start_ok    = s1_valid && s1_start && (st[wr_ptr] != BUF_FULL);
    cont        = s1_valid && !s1_start && filling;
    wr_go_nxt   = start_ok || cont;
    wr_pix      = start_ok ? '0 : pix;
    wr_bank_nxt = wr_pix[0];
    last        = wr_go_nxt && (wr_pix == PW'(FRAME_PIX - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBUF; i++) st[i] <= BUF_FREE;
      wr_ptr  <= '0;
      pix     <= '0;
      filling <= 1'b0;
      wr_we   <= 2'b00;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_we   <= wr_go_nxt ? (wr_bank_nxt ? 2'b10 : 2'b01) : 2'b00;
      wr_addr <= {wr_ptr, wr_pix[PW-1:1]};
      wr_data <= s1_data;
      if (done) st[done_buf] <= BUF_FREE;
      if (start_ok) begin
        st[wr_ptr] <= BUF_FILL;
        filling    <= 1'b1;
        pix        <= PW'(1);
      end else if (s1_valid && s1_start) begin
        filling <= 1'b0;
      end else if (cont) begin
        pix <= pix + PW'(1);
      end
      if (last) begin
        st[wr_ptr] <= BUF_FULL;
        filling    <= 1'b0;
        pix        <= '0;
        wr_ptr     <= (wr_ptr == BW'(NBUF - 1)) ? '0 : wr_ptr + BW'(1);
      end
    end
  end

  for (genvar g = 0; g < NBUF; g++) begin : g_full
    assign buf_full[g] = (st[g] == BUF_FULL);

    // R6
    full_from_fill_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(buf_full[g]) |-> $past(st[g]) == BUF_FILL);
  end

  // R7
  release_full_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> buf_full[done_buf]);

  // R5
  one_bank_write_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_we));
endmodule

// File: rtl/fdb_rd_path.sv
// Read side: drains full buffers in ring order, takes the bank slot the
// writer leaves idle, and queues returning data for the valid/ready output.
module fdb_rd_path #(
  parameter int DATA_W    = 8,
  parameter int FRAME_PIX = 64,
  parameter int NBUF      = 2,
  parameter int OQ_DEPTH  = 4,
  localparam int PW = $clog2(FRAME_PIX),
  localparam int BW = $clog2(NBUF),
  localparam int AW = BW + PW - 1,
  localparam int QW = $clog2(OQ_DEPTH),
  localparam int CW = $clog2(OQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NBUF-1:0]   buf_full,
  input  logic              wr_go_nxt,
  input  logic              wr_bank_nxt,
  input  logic [DATA_W-1:0] mem_rdata0,
  input  logic [DATA_W-1:0] mem_rdata1,
  input  logic              out_ready,
  output logic              done,
  output logic [BW-1:0]     done_buf,
  output logic [1:0]        rd_re,
  output logic [AW-1:0]     rd_addr,
  output logic              out_valid,
  output logic              out_sof,
  output logic [DATA_W-1:0] out_data
);
  logic              active;
  logic [BW-1:0]     rd_ptr;
  logic [PW-1:0]     rpix;
  logic              p1_v, p1_bank, p1_sof;
  logic              p2_v, p2_bank, p2_sof;
  logic [DATA_W-1:0] q_data [OQ_DEPTH];
  logic              q_sof  [OQ_DEPTH];
  logic [QW-1:0]     wp, rp;
  logic [CW-1:0]     cnt;
  logic              credit_ok, issue, rlast, push, pop;

  always_comb begin
    credit_ok = (int'(cnt) + int'(p1_v) + int'(p2_v)) < OQ_DEPTH;
    issue     = active && credit_ok && !(wr_go_nxt && (wr_bank_nxt == rpix[0]));
    rlast     = (rpix == PW'(FRAME_PIX - 1));
    done      = issue && rlast;
    done_buf  = rd_ptr;
    push      = p2_v;
    pop       = out_valid && out_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      rd_ptr  <= '0;
      rpix    <= '0;
      rd_re   <= 2'b00;
      rd_addr <= '0;
      p1_v    <= 1'b0;
      p1_bank <= 1'b0;
      p1_sof  <= 1'b0;
      p2_v    <= 1'b0;
      p2_bank <= 1'b0;
      p2_sof  <= 1'b0;
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
    end else begin
      if (!active && buf_full[rd_ptr]) begin
        active <= 1'b1;
        rpix   <= '0;
      end
      if (issue) begin
        rd_re   <= rpix[0] ? 2'b10 : 2'b01;
        rd_addr <= {rd_ptr, rpix[PW-1:1]};
        p1_v    <= 1'b1;
        p1_bank <= rpix[0];
        p1_sof  <= (rpix == '0);
        rpix    <= rpix + PW'(1);
        if (rlast) begin
          active <= 1'b0;
          rpix   <= '0;
          rd_ptr <= (rd_ptr == BW'(NBUF - 1)) ? '0 : rd_ptr + BW'(1);
        end
      end else begin
        rd_re <= 2'b00;
        p1_v  <= 1'b0;
      end
      p2_v    <= p1_v;
      p2_bank <= p1_bank;
      p2_sof  <= p1_sof;
      if (push) wp <= wp + QW'(1);
      if (pop)  rp <= rp + QW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_data[wp] <= p2_bank ? mem_rdata1 : mem_rdata0;
      q_sof[wp]  <= p2_sof;
    end
  end

  assign out_valid = (cnt != '0);
  assign out_data  = q_data[rp];
  assign out_sof   = q_sof[rp];

  // R8
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(out_valid) && !$past(out_ready)) |->
      (out_valid && $stable(out_data) && $stable(out_sof)));

  // R9
  idle_after_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);
endmodule

// File: rtl/frame_decim_buf.sv
module frame_decim_buf #(
  parameter int DATA_W    = 8,
  parameter int FRAME_PIX = 64,
  parameter int NBUF      = 2,
  parameter int OQ_DEPTH  = 4,
  localparam int AW = $clog2(NBUF) + $clog2(FRAME_PIX) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sof,
  output logic [DATA_W-1:0] out_data,
  output logic [1:0]        mem_we,
  output logic [1:0]        mem_re,
  output logic [AW-1:0]     mem_addr0,
  output logic [AW-1:0]     mem_addr1,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata0,
  input  logic [DATA_W-1:0] mem_rdata1
);
  localparam int BW = $clog2(NBUF);

  logic              s1_valid, s1_start;
  logic [DATA_W-1:0] s1_data;
  logic [NBUF-1:0]   buf_full;
  logic              wr_go_nxt, wr_bank_nxt, done;
  logic [BW-1:0]     done_buf;
  logic [1:0]        wr_we, rd_re;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [AW-1:0]     bank_addr [2];

  fdb_sof_det #(.DATA_W(DATA_W)) u_det (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .s1_valid(s1_valid), .s1_start(s1_start), .s1_data(s1_data)
  );

  fdb_buf_mgr #(.DATA_W(DATA_W), .FRAME_PIX(FRAME_PIX), .NBUF(NBUF)) u_mgr (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_start(s1_start), .s1_data(s1_data),
    .done(done), .done_buf(done_buf), .buf_full(buf_full),
    .wr_go_nxt(wr_go_nxt), .wr_bank_nxt(wr_bank_nxt),
    .wr_we(wr_we), .wr_addr(wr_addr), .wr_data(mem_wdata)
  );

  fdb_rd_path #(.DATA_W(DATA_W), .FRAME_PIX(FRAME_PIX), .NBUF(NBUF),
                .OQ_DEPTH(OQ_DEPTH)) u_rd (
    .clk(clk), .rst(rst), .buf_full(buf_full),
    .wr_go_nxt(wr_go_nxt), .wr_bank_nxt(wr_bank_nxt),
    .mem_rdata0(mem_rdata0), .mem_rdata1(mem_rdata1), .out_ready(out_ready),
    .done(done), .done_buf(done_buf), .rd_re(rd_re), .rd_addr(rd_addr),
    .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign bank_addr[b] = wr_we[b] ? wr_addr : rd_addr;

    // R5
    no_bank_clash_chk: assert property (@(posedge clk) disable iff (rst)
      !(mem_we[b] && mem_re[b]));
  end

  assign mem_we    = wr_we;
  assign mem_re    = rd_re;
  assign mem_addr0 = bank_addr[0];
  assign mem_addr1 = bank_addr[1];
endmodule

// File: tb/frame_decim_buf_test.sv
module frame_decim_buf_test;
  localparam int DW = 8;
  localparam int FP = 8;
  localparam int AW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_valid, out_sof;
  logic [DW-1:0] out_data, mem_wdata, mem_rdata0, mem_rdata1;
  logic [1:0] mem_we, mem_re;
  logic [AW-1:0] mem_addr0, mem_addr1;

  logic [DW-1:0] bank0 [8];
  logic [DW-1:0] bank1 [8];

  int tests = 0, fails = 0, clash = 0, cyc = 0, rdy_mod = 0;
  int cur_n = 0, cur_id = 0, ndel = 0, bad_frames = 0;
  bit cur_ok;
  int deliv [64];

  frame_decim_buf #(.DATA_W(DW), .FRAME_PIX(FP), .NBUF(2), .OQ_DEPTH(4)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_sof(out_sof), .out_data(out_data),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr0(mem_addr0), .mem_addr1(mem_addr1),
    .mem_wdata(mem_wdata), .mem_rdata0(mem_rdata0), .mem_rdata1(mem_rdata1)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we[0]) bank0[mem_addr0] <= mem_wdata;
    if (mem_re[0]) mem_rdata0 <= bank0[mem_addr0];
    if (mem_we[1]) bank1[mem_addr1] <= mem_wdata;
    if (mem_re[1]) mem_rdata1 <= bank1[mem_addr1];
  end

  always @(posedge clk) begin
    cyc++;
    #1 out_ready = (rdy_mod == 0) ? 1'b0 : ((cyc % rdy_mod) == 0);
  end

  // Frame assembly at the consumer: each finished frame must be whole.
  always @(negedge clk) begin
    if (rst) begin
      cur_n = 0; ndel = 0; bad_frames = 0;
    end else begin
      if ((mem_we & mem_re) != 2'b00) clash++;
      if (out_valid && out_ready) begin
        if (out_sof) begin
          if (cur_n != 0) bad_frames++;
          cur_n = 1; cur_id = int'(out_data[7:3]); cur_ok = (out_data[2:0] == 3'd0);
        end else if (cur_n == 0) begin
          bad_frames++;
        end else begin
          if (out_data != {cur_id[4:0], cur_n[2:0]}) cur_ok = 1'b0;
          cur_n++;
        end
        if (cur_n == FP) begin
          if (!cur_ok) bad_frames++;
          deliv[ndel] = cur_id;
          ndel++;
          cur_n = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst = 1'b1; in_valid = 1'b0; in_sof = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic send_frame(input int id, input int npix, input int gap);
    for (int p = 0; p < npix; p++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_sof = (p == 0);
      in_data = {id[4:0], p[2:0]};
      for (int g = 0; g < gap; g++) begin
        @(posedge clk); #1 in_valid = 1'b0; in_sof = 1'b0;
      end
    end
    @(posedge clk); #1 in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic send_stray(input int n);
    for (int p = 0; p < n; p++) begin
      @(posedge clk); #1 in_valid = 1'b1; in_sof = 1'b0; in_data = 8'hF0 | p[7:0];
    end
    @(posedge clk); #1 in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    #5;
    // R9: idle outputs after reset
    chk(out_valid == 1'b0, "R9 out_valid", int'(out_valid), 0);
    chk(mem_we == 2'b00 && mem_re == 2'b00, "R9 strobes", int'({mem_we, mem_re}), 0);

    // Slow source, eager consumer: every frame kept, in order (R2, R3)
    rdy_mod = 1;
    for (int f = 0; f < 4; f++) send_frame(f, FP, 2);
    idle(120);
    chk(ndel == 4, "R2 all kept count", ndel, 4);
    for (int k = 0; k < 4; k++) chk(deliv[k] == k, "R3 order", deliv[k], k);

    // Stalled consumer: frames 4,5 kept, 6..8 dropped (R2, R7)
    do_reset();
    rdy_mod = 0;
    for (int f = 4; f < 9; f++) send_frame(f, FP, 0);
    idle(20);
    // R4: pixel p of buffer b at bank p[0], address {b, p>>1}
    for (int k = 0; k < 4; k++) begin
      chk(bank0[k] == {5'd4, 3'(2*k)}, "R4 buf0 bank0", int'(bank0[k]), int'({5'd4, 3'(2*k)}));
      chk(bank1[k] == {5'd4, 3'(2*k+1)}, "R4 buf0 bank1", int'(bank1[k]), int'({5'd4, 3'(2*k+1)}));
      chk(bank0[4+k] == {5'd5, 3'(2*k)}, "R4 buf1 bank0", int'(bank0[4+k]), int'({5'd5, 3'(2*k)}));
      chk(bank1[4+k] == {5'd5, 3'(2*k+1)}, "R4 buf1 bank1", int'(bank1[4+k]), int'({5'd5, 3'(2*k+1)}));
    end
    // R8: held head while stalled
    chk(out_valid && out_sof && out_data == {5'd4, 3'd0}, "R8 held head", int'(out_data), int'({5'd4, 3'd0}));
    idle(5);
    chk(out_valid && out_sof && out_data == {5'd4, 3'd0}, "R8 still held", int'(out_data), int'({5'd4, 3'd0}));
    rdy_mod = 1;
    idle(60);
    chk(ndel == 2, "R2 drops while full", ndel, 2);
    chk(deliv[0] == 4 && deliv[1] == 5, "R7 kept frames", deliv[0]*100 + deliv[1], 405);
    send_frame(9, FP, 1);
    idle(60);
    chk(ndel == 3 && deliv[2] == 9, "R7 buffer reused after drain", deliv[2], 9);

    // Truncated, overlong and stray input (R1, R6)
    do_reset();
    rdy_mod = 1;
    send_frame(9, 3, 2);
    send_frame(10, FP, 2);
    send_frame(11, 10, 2);
    idle(60);
    send_stray(5);
    send_frame(12, FP, 2);
    idle(60);
    chk(ndel == 3, "R6 truncated dropped count", ndel, 3);
    chk(deliv[0] == 10, "R6 truncated frame discarded", deliv[0], 10);
    chk(deliv[1] == 11, "R6 overlong frame trimmed", deliv[1], 11);
    chk(deliv[2] == 12, "R1 stray pixels ignored", deliv[2], 12);
    chk(bad_frames == 0, "R8 whole frames", bad_frames, 0);

    // Sweep of consumer rates with a continuous source (R3, R5, R8)
    for (int m = 1; m <= 5; m++) begin
      do_reset();
      rdy_mod = m;
      for (int f = 0; f < 12; f++) send_frame(f, FP, 0);
      idle(200);
      chk(ndel >= 1 && deliv[0] == 0, "R2 first frame kept", deliv[0], 0);
      for (int k = 1; k < ndel; k++)
        chk(deliv[k] > deliv[k-1] && deliv[k] < 12, "R3 ascending ids", deliv[k], deliv[k-1] + 1);
      chk(bad_frames == 0 && cur_n == 0, "R8 no partial frame", bad_frames, 0);
    end
    chk(clash == 0, "R5 bank clash cycles", clash, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule